// File: doc/BRIEF.md
# Byte-Lane Dual-Port Register File

This block is a register file with one write port and one read port. Each port has its own address and both share a single clock. A write stores only those byte lanes whose enable bit is set. A read is synchronous: the word at the address sampled on a rising edge appears on the read output just after that edge, and it stays there until a later edge loads a new word.

A same-address read and write in the same cycle is called a collision. How a collision resolves is fixed at elaboration by the `TRANSPARENT` parameter; it is not an input.

- **Write-through** (`TRANSPARENT=1`): the read returns the incoming data on every lane being written. Lanes that are not being written return the stored contents.
- **Read-old** (`TRANSPARENT=0`): the read returns the whole word as it stood before the write.

The default configuration has 128 entries of 32 bits with four 8-bit lanes. The address width, data width and lane count are parameters. The data width must be a whole multiple of the lane count.

Top module: `lane_regfile`

## Requirements
- R1: While `rst_n` is low, the read output register is cleared to zero. Array contents are not reset.
- R2: A write with all lane enables set stores the whole word. A later read of that address returns it.
- R3: Read data is registered. The word for the address sampled on an edge appears after that edge, and the output does not change before it.
- R4: Write enable bit `l` gates only lane `l`, which is bits `[8l+7:8l]` in the default configuration. Lanes with a clear enable keep their stored value.
- R5: With `TRANSPARENT=1`, a collision returns the write data on every lane whose enable is set.
- R6: With `TRANSPARENT=1`, a collision returns the stored array contents on every lane whose enable is clear.
- R7: With `TRANSPARENT=0`, a collision returns the full word held before that write, on every lane.
- R8: With `TRANSPARENT=0`, a read after a collision returns the most recently written value of that location.
- R9: A write to an address other than the read address has no effect on the read data returned for that cycle.
- R10: While the read address is held and the location is not written, the read output stays unchanged from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous clear of the read output register |
| wr_addr | input | ADDR_W | Write address |
| wr_we | input | LANES | Per-lane write enables; bit l gates lane l |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address, sampled on each rising edge |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench drives two instances with the same inputs, one write-through and one read-old, on a 16-entry array. It sweeps every address and all 16 lane-enable patterns. Lane-masked writes while the read port is on another address show whether a clear enable protects its lane and whether a write elsewhere disturbs the read. A collision swept over all 16 masks separates forwarded lanes from stored lanes and separates the two modes. The follow-up read, a run with the read address held, and a check of the output just before each edge confirm that the new value has landed, that the output is stable, and that the read takes one cycle.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

  // Width of one byte lane for a given word and lane count.
  function automatic int lane_bits(input int data_w, input int lanes);
    return data_w / lanes;
  endfunction

  // True when a word splits into equal whole lanes.
  function automatic bit lanes_fit(input int data_w, input int lanes);
    return (lanes > 0) && (data_w % lanes == 0);
  endfunction

  // Number of entries addressed by an address of the given width.
  function automatic int entries(input int addr_w);
    return 1 << addr_w;
  endfunction

endpackage

// File: rtl/lrf_array.sv
module lrf_array
  import lrf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = entries(ADDR_W);
  localparam int LW    = lane_bits(DATA_W, LANES);

  logic [DATA_W-1:0] mem [DEPTH];

  // Lane-masked write: each enable bit touches only its own slice.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_we[l]) begin
        mem[wr_addr][l*LW +: LW] <= wr_data[l*LW +: LW];
      end
    end
  end

  // Stored word at the read address, before any write of this cycle.
  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/lrf_bypass.sv
module lrf_bypass
  import lrf_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 32,
  parameter int LANES       = 4,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] arr_word,
  output logic              collide,
  output logic [LANES-1:0]  fwd_mask,
  output logic [DATA_W-1:0] next_word
);
  localparam int LW = lane_bits(DATA_W, LANES);

  assign collide = (rd_addr == wr_addr) && (|wr_we);

  generate
    if (TRANSPARENT) begin : g_write_through
      assign fwd_mask = collide ? wr_we : '0;
    end else begin : g_read_old
      assign fwd_mask = '0;
    end
  endgenerate

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign next_word[l*LW +: LW] = fwd_mask[l] ? wr_data[l*LW +: LW]
                                                : arr_word[l*LW +: LW];
  end

endmodule

// File: rtl/lrf_rdreg.sv
module lrf_rdreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
  import lrf_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 32,
  parameter int LANES       = 4,
  parameter bit TRANSPARENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  generate
    if (!lanes_fit(DATA_W, LANES)) begin : g_bad_split
      $error("lane_regfile: DATA_W must be a multiple of LANES");
    end
  endgenerate

  // Named internal events, observed by the bound checker.
  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] next_rd;
  logic              collide;
  logic [LANES-1:0]  fwd_mask;

  lrf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .wr_addr (wr_addr),
    .wr_we   (wr_we),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_word (arr_rd)
  );

  lrf_bypass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
               .TRANSPARENT(TRANSPARENT)) u_bypass (
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .wr_we     (wr_we),
    .wr_data   (wr_data),
    .arr_word  (arr_rd),
    .collide   (collide),
    .fwd_mask  (fwd_mask),
    .next_word (next_rd)
  );

  lrf_rdreg #(.DATA_W(DATA_W)) u_rdreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (next_rd),
    .q     (rd_data)
  );

endmodule

// File: rtl/lrf_checker.sv
module lrf_checker #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 32,
  parameter int LANES       = 4,
  parameter bit TRANSPARENT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LANES-1:0]  wr_we,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] arr_rd,
  input logic              collide
);
  localparam int LW = DATA_W / LANES;

  function automatic logic [DATA_W-1:0] bit_mask(input logic [LANES-1:0] en);
    logic [DATA_W-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*LW +: LW] = {LW{en[l]}};
    return m;
  endfunction

  // R1: a reset cycle leaves the output register at zero.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0));

  // R3, R9: without a collision, the output is the array word from one edge before.
  assert_plain_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !collide |=> (rd_data == $past(arr_rd)));

  // R10: held address with no writes keeps the output steady.
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rd_addr == $past(rd_addr) && wr_we == '0 && $past(wr_we) == '0)
    |=> $stable(rd_data));

  generate
    if (TRANSPARENT) begin : g_wt
      // R5: enabled lanes take the write data.
      assert_fwd_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> ((rd_data & $past(bit_mask(wr_we))) ==
                     ($past(wr_data) & $past(bit_mask(wr_we)))));
      // R6: disabled lanes take the stored word.
      assert_kept_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> ((rd_data & ~$past(bit_mask(wr_we))) ==
                     ($past(arr_rd) & ~$past(bit_mask(wr_we)))));
    end else begin : g_ro
      // R7: the whole word is the pre-write value.
      assert_old_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (rd_data == $past(arr_rd)));
    end
  endgenerate

endmodule

bind lane_regfile lrf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .TRANSPARENT(TRANSPARENT)
) u_lrf_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_addr (wr_addr),
  .wr_we   (wr_we),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .arr_rd  (arr_rd),
  .collide (collide)
);

// File: tb/lane_regfile_test.sv
`timescale 1ns/1ps
module lane_regfile_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NL = 4;
  localparam int NE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [NL-1:0] wr_we = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_t, rd_n;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [DW-1:0] model [NE];
  logic [DW-1:0] prev_t, prev_n;
  bit prev_ok = 1'b0;

  always #5 clk = ~clk;

  lane_regfile #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL), .TRANSPARENT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_we(wr_we),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_t));

  lane_regfile #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL), .TRANSPARENT(1'b0)) uut_nt (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_we(wr_we),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_n));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return (32'h1357_9BDF * (a + 1)) ^ (salt * 32'h0F0F_0101);
  endfunction

  // Byte-lane mask built arithmetically: lane l covers bits 8l..8l+7.
  function automatic logic [DW-1:0] lanes_to_bits(input logic [NL-1:0] en);
    logic [DW-1:0] m = '0;
    for (int l = 0; l < NL; l++) if (en[l]) m = m | (32'hFF << (8 * l));
    return m;
  endfunction

  // One clocked access on both instances; checks are skipped when do_chk is 0.
  task automatic step(input logic [AW-1:0] wa, input logic [NL-1:0] we,
                      input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                      input bit do_chk, input string tag);
    logic [DW-1:0] old, m, exp_t, exp_n;
    bit hit;
    @(negedge clk);
    wr_addr = wa; wr_we = we; wr_data = wd; rd_addr = ra;
    old = model[ra];
    m = lanes_to_bits(we);
    hit = (wa == ra) && (we != '0);
    exp_t = hit ? ((wd & m) | (old & ~m)) : old;
    exp_n = old;
    #1;
    if (do_chk && prev_ok) begin
      chk("R3 pre-edge write-through", rd_t, prev_t);
      chk("R3 pre-edge read-old", rd_n, prev_n);
    end
    model[wa] = (wd & m) | (model[wa] & ~m);
    @(posedge clk);
    #1;
    if (do_chk) begin
      if (hit) begin
        chk("R5 enabled lanes", rd_t & m, exp_t & m);
        chk("R6 disabled lanes", rd_t & ~m, exp_t & ~m);
        chk("R7 read-old collision", rd_n, exp_n);
      end else begin
        chk({tag, " write-through"}, rd_t, exp_t);
        chk({tag, " read-old"}, rd_n, exp_n);
      end
    end
    prev_t = exp_t; prev_n = exp_n; prev_ok = do_chk;
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset write-through", rd_t, '0);
    chk("R1 reset read-old", rd_n, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill every entry with full-lane writes, reading a distinct address.
    for (int a = 0; a < NE; a++) begin
      model[a] = '0;
    end
    for (int a = 0; a < NE; a++) begin
      step(a[AW-1:0], 4'hF, pat(a, 0), 4'(NE - 1 - a), 1'b0, "fill");
    end
    // R2: read back every entry.
    for (int a = 0; a < NE; a++) begin
      step('0, '0, '0, a[AW-1:0], 1'b1, "R2 readback");
    end

    // R4 and R9: every lane mask written while reading a different address.
    for (int k = 0; k < 16; k++) begin
      step(k[AW-1:0], k[NL-1:0], ~pat(k, 3), 4'(k + 1), 1'b1, "R9 other-address read");
      step('0, '0, '0, k[AW-1:0], 1'b1, "R4 lane mask");
    end

    // R5, R6, R7 on collisions over all masks, then R8 on the follow-up read.
    for (int k = 0; k < 16; k++) begin
      step(k[AW-1:0], k[NL-1:0], pat(k, 7), k[AW-1:0], 1'b1, "R5 collision");
      step('0, '0, '0, k[AW-1:0], 1'b1, "R8 after collision");
    end

    // R10: held address, no writes.
    for (int i = 0; i < 5; i++) begin
      step('0, '0, '0, 4'd5, 1'b1, "R10 hold");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule